// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the bit clock of a synchronous serial master from a faster reference clock. The division is split into two cascaded settings: an integer prescaler of 1 to 32 and a binary stage of 1, 2, 4, 8, 16 or 32. Their product is the number of reference cycles between two successive serial clock edges, so one serial clock period spans twice that product. The largest product is 1024.

The caller computes the wanted ratio outside the block and presents it together with a one-cycle load pulse. The block searches for the binary stage and the prescaler that suit that ratio. It stores the chosen pair in a transmit clock register and, unless the receive-slaved-to-transmit mode is selected, in a receive clock register as well. The serial clock generator runs from the transmit register.

A new setting reaches the generator only at the end of a serial clock period, so no high or low phase is ever cut short by a reconfiguration. Each serial clock edge comes with a one-cycle strobe.

Top module: `serclk_twostage_div`

## Requirements
- R1: After reset both clock registers hold prescaler code 31 and binary code 5, which is a ratio of 1024. The serial clock and both strobes are low.
- R2: For a requested ratio R from 1 to 1024, the binary code is the smallest k in 0..5 for which ceil(R / 2^k) is at most 32. The prescaler field holds ceil(R / 2^k) - 1.
- R3: A requested ratio of 0 is handled as 1024 and gives prescaler code 31 with binary code 5.
- R4: A requested ratio above 1024 gives prescaler code 31 with binary code 5.
- R5: With the slaved-receive mode off, a load pulse writes the same setting into the transmit and the receive register, visible one cycle after the pulse.
- R6: With the slaved-receive mode on, a load pulse updates the transmit register and leaves the receive register unchanged.
- R7: Without a load pulse both registers keep their contents, whatever the ratio input does.
- R8: While run is high, the serial clock toggles every N reference cycles, where N = (prescaler code + 1) * 2^(binary code), and binary codes 6 and 7 count as 5. The first rising edge lands N cycles after run is first sampled high.
- R9: The rise strobe is high exactly in the first cycle in which the serial clock is high. The fall strobe is high exactly in the first cycle in which it is low. The two strobes are never high together.
- R10: While running, a changed setting takes effect only at a falling serial clock edge: the high phase in progress and the low phase already started keep their old length. While run is low, the serial clock stays low and the setting is taken over at once.
- R11: With a ratio of 1, the serial clock toggles on every reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that loads a new requested ratio |
| req_ratio | input | REQ_W (11) | Requested ratio; 0 or above 1024 selects 1024 |
| rx_follows_tx | input | 1 | Slaved-receive mode: when high, a load does not write the receive register |
| run | input | 1 | Serial clock runs while high and is held low otherwise |
| tx_psc | output | PSC_W (5) | Transmit prescaler field (value minus one) |
| tx_pow | output | POW_W (3) | Transmit binary-stage code (divide by 2^code) |
| rx_psc | output | PSC_W (5) | Receive prescaler field (value minus one) |
| rx_pow | output | POW_W (3) | Receive binary-stage code |
| sclk | output | 1 | Serial clock |
| sclk_rise | output | 1 | One-cycle strobe in the first high cycle of sclk |
| sclk_fall | output | 1 | One-cycle strobe in the first low cycle of sclk |

## Verification
Some properties are checked on every cycle. The chosen product must cover the request and stay below request plus 2^k. The receive register must either copy the transmit register or hold, depending on the mode. The serial clock may only change when its countdown expires, the strobes must match the clock level, and the active ratio may change during a run only at a falling edge. Other properties need the bench's scenarios. That the binary code is the smallest legal one is shown by a sweep over every request from 0 to 1100. The exact cycle count to the first edge, the half-period lengths for several ratios including 1, and the deferred takeover of a setting loaded mid-phase are shown by directed runs.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

   localparam int unsigned PSC_W_D = 5;
   localparam int unsigned POW_W_D = 3;
   localparam int unsigned POW_N_D = 6;
   localparam int unsigned REQ_W_D = 11;

   // Total reference cycles per serial half period for a stored setting.
   function automatic int unsigned div_of(input int unsigned psc_code,
                                          input int unsigned pow_code,
                                          input int unsigned pow_top);
      int unsigned p;
      p = (pow_code > pow_top) ? pow_top : pow_code;
      return (psc_code + 1) << p;
   endfunction

endpackage

// File: rtl/serclk_pick.sv
module serclk_pick #(
   parameter int unsigned PSC_W = serclk_pkg::PSC_W_D,
   parameter int unsigned POW_W = serclk_pkg::POW_W_D,
   parameter int unsigned POW_N = serclk_pkg::POW_N_D,
   parameter int unsigned REQ_W = serclk_pkg::REQ_W_D
) (
   input  logic [REQ_W-1:0] req,
   output logic [PSC_W-1:0] psc_code,
   output logic [POW_W-1:0] pow_code
);
   localparam int unsigned PSC_MAX = 1 << PSC_W;
   localparam int unsigned MAXR    = PSC_MAX << (POW_N - 1);

   logic [REQ_W-1:0] eff;
   logic [REQ_W-1:0] quo [POW_N];
   logic [POW_N-1:0] fits;

   // Zero and anything past the top ratio fall back to the top ratio.
   assign eff = (req == '0 || req > REQ_W'(MAXR)) ? REQ_W'(MAXR) : req;

   for (genvar k = 0; k < POW_N; k++) begin : g_opt
      assign quo[k]  = REQ_W'((32'(eff) + (32'd1 << k) - 32'd1) >> k);
      assign fits[k] = (quo[k] <= REQ_W'(PSC_MAX));
   end

   // Scan from the widest option down so the narrowest fitting one wins.
   always_comb begin
      pow_code = POW_W'(POW_N - 1);
      psc_code = PSC_W'(quo[POW_N-1] - 1'b1);
      for (int k = POW_N - 1; k >= 0; k--) begin
         if (fits[k]) begin
            pow_code = POW_W'(k);
            psc_code = PSC_W'(quo[k] - 1'b1);
         end
      end
   end
endmodule

// File: rtl/serclk_cfgreg.sv
module serclk_cfgreg #(
   parameter int unsigned       W       = 8,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         rx_hold,
   input  logic [W-1:0] new_cfg,
   output logic [W-1:0] tx_cfg,
   output logic [W-1:0] rx_cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_cfg <= RST_VAL;
         rx_cfg <= RST_VAL;
      end else if (load) begin
         tx_cfg <= new_cfg;
         if (!rx_hold) rx_cfg <= new_cfg;
      end
   end

   // R5: both registers carry the same setting after a full load
   a_r5_rx_copies_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !rx_hold) |=> (rx_cfg == tx_cfg));
   // R6: slaved-receive mode leaves the receive register alone
   a_r6_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (load && rx_hold) |=> $stable(rx_cfg));
   // R7: no load, no change
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(tx_cfg) && $stable(rx_cfg)));
endmodule

// File: rtl/serclk_edge_gen.sv
module serclk_edge_gen #(
   parameter int unsigned PSC_W = serclk_pkg::PSC_W_D,
   parameter int unsigned POW_W = serclk_pkg::POW_W_D,
   parameter int unsigned POW_N = serclk_pkg::POW_N_D,
   parameter int unsigned CNT_W = serclk_pkg::REQ_W_D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc_code,
   input  logic [POW_W-1:0] pow_code,
   output logic             sclk,
   output logic             rise,
   output logic             fall
);
   localparam int unsigned POW_TOP = POW_N - 1;
   localparam int unsigned MAXR    = (1 << PSC_W) << POW_TOP;

   logic [POW_W-1:0] pow_sat;
   logic [CNT_W-1:0] n_cfg, n_act, cnt;

   // Unused binary codes saturate to the widest stage.
   assign pow_sat = (pow_code > POW_W'(POW_TOP)) ? POW_W'(POW_TOP) : pow_code;
   assign n_cfg   = CNT_W'((32'(psc_code) + 32'd1) << pow_sat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk  <= 1'b0;
         rise  <= 1'b0;
         fall  <= 1'b0;
         n_act <= CNT_W'(MAXR);
         cnt   <= CNT_W'(MAXR - 1);
      end else if (!run) begin
         sclk  <= 1'b0;
         rise  <= 1'b0;
         fall  <= sclk;
         n_act <= n_cfg;
         cnt   <= n_cfg - 1'b1;
      end else if (cnt == '0) begin
         sclk <= ~sclk;
         rise <= ~sclk;
         fall <= sclk;
         if (sclk) begin
            // falling edge closes a period: the only point a new ratio enters
            n_act <= n_cfg;
            cnt   <= n_cfg - 1'b1;
         end else begin
            cnt   <= n_act - 1'b1;
         end
      end else begin
         cnt  <= cnt - 1'b1;
         rise <= 1'b0;
         fall <= 1'b0;
      end
   end

   // R9: strobes are exclusive and match the clock level they announce
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall}));
   a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (sclk && !$past(sclk)));
   a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> (!sclk && $past(sclk)));
   // R8: while running, the clock only moves when the countdown has expired
   a_r8_toggle_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$stable(sclk)) |-> ($past(cnt) == '0));
   // R10: a running clock takes over a new ratio only at a falling edge
   a_r10_adopt_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$stable(n_act)) |-> fall);
endmodule

// File: rtl/serclk_twostage_div.sv
module serclk_twostage_div #(
   parameter int unsigned PSC_W = serclk_pkg::PSC_W_D,
   parameter int unsigned POW_W = serclk_pkg::POW_W_D,
   parameter int unsigned POW_N = serclk_pkg::POW_N_D,
   parameter int unsigned REQ_W = serclk_pkg::REQ_W_D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [REQ_W-1:0] req_ratio,
   input  logic             rx_follows_tx,
   input  logic             run,
   output logic [PSC_W-1:0] tx_psc,
   output logic [POW_W-1:0] tx_pow,
   output logic [PSC_W-1:0] rx_psc,
   output logic [POW_W-1:0] rx_pow,
   output logic             sclk,
   output logic             sclk_rise,
   output logic             sclk_fall
);
   localparam int unsigned CFG_W   = PSC_W + POW_W;
   localparam int unsigned POW_TOP = POW_N - 1;
   localparam int unsigned MAXR    = (1 << PSC_W) << POW_TOP;
   localparam logic [CFG_W-1:0] CFG_RST = {POW_W'(POW_TOP), {PSC_W{1'b1}}};

   if (POW_N < 1 || POW_N > (1 << POW_W)) begin : g_bad_pow
      $error("POW_N does not fit the binary-stage code width");
   end
   if (REQ_W < $clog2(MAXR + 1)) begin : g_bad_req
      $error("REQ_W too narrow for the largest ratio");
   end

   logic [PSC_W-1:0] pick_psc;
   logic [POW_W-1:0] pick_pow;
   logic [CFG_W-1:0] tx_cfg, rx_cfg;

   serclk_pick #(.PSC_W(PSC_W), .POW_W(POW_W), .POW_N(POW_N), .REQ_W(REQ_W)) u_pick (
      .req      (req_ratio),
      .psc_code (pick_psc),
      .pow_code (pick_pow)
   );

   serclk_cfgreg #(.W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .rx_hold (rx_follows_tx),
      .new_cfg ({pick_pow, pick_psc}),
      .tx_cfg  (tx_cfg),
      .rx_cfg  (rx_cfg)
   );

   assign {tx_pow, tx_psc} = tx_cfg;
   assign {rx_pow, rx_psc} = rx_cfg;

   serclk_edge_gen #(.PSC_W(PSC_W), .POW_W(POW_W), .POW_N(POW_N), .CNT_W(REQ_W)) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .psc_code (tx_psc),
      .pow_code (tx_pow),
      .sclk     (sclk),
      .rise     (sclk_rise),
      .fall     (sclk_fall)
   );

   function automatic int unsigned clamp_req(input logic [REQ_W-1:0] r);
      return (r == '0 || 32'(r) > MAXR) ? MAXR : 32'(r);
   endfunction

   // R2: the stored product never falls short of the request
   a_r2_covers: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (serclk_pkg::div_of(32'(tx_psc), 32'(tx_pow), POW_TOP)
                    >= clamp_req($past(req_ratio))));
   // R2: and overshoots by less than one binary step
   a_r2_tight: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (serclk_pkg::div_of(32'(tx_psc), 32'(tx_pow), POW_TOP)
                    < clamp_req($past(req_ratio)) + (32'd1 << tx_pow)));
endmodule

// File: tb/test_serclk_twostage_div.sv
`timescale 1ns/1ps
module test_serclk_twostage_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [10:0] req_ratio = '0;
   logic        rx_follows_tx = 1'b0;
   logic        run = 1'b0;
   logic [4:0]  tx_psc, rx_psc;
   logic [2:0]  tx_pow, rx_pow;
   logic        sclk, sclk_rise, sclk_fall;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serclk_twostage_div i_serclk_twostage_div (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .req_ratio(req_ratio),
      .rx_follows_tx(rx_follows_tx), .run(run),
      .tx_psc(tx_psc), .tx_pow(tx_pow), .rx_psc(rx_psc), .rx_pow(rx_pow),
      .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Expected setting from the requirement arithmetic: value n (1..32), code k
   function automatic void model(input int r, output int n, output int k);
      int e;
      e = (r == 0 || r > 1024) ? 1024 : r;
      k = 5;
      n = (e + 31) / 32;
      for (int j = 5; j >= 0; j--) begin
         int q;
         q = (e + (1 << j) - 1) / (1 << j);
         if (q <= 32) begin
            k = j;
            n = q;
         end
      end
   endfunction

   task automatic wait_strobe(input bit want_rise, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(want_rise ? sclk_rise : sclk_fall) && n < 5000);
      chk(want_rise ? "R9 level at rise" : "R9 level at fall", sclk, want_rise);
      chk("R9 strobes exclusive", sclk_rise & sclk_fall, 0);
   endtask

   task automatic load_idle(input int r);
      @(negedge clk);
      run = 1'b0;
      req_ratio = 11'(r);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
      chk("R10 idle clock low", sclk, 0);
   endtask

   task automatic run_ratio(input int r, input int halves, input string tag);
      int n, k, nn, got;
      model(r, n, k);
      nn = n << k;
      load_idle(r);
      @(negedge clk);
      run = 1'b1;
      wait_strobe(1'b1, got);
      chk({tag, " first rise"}, got, nn);
      for (int h = 0; h < halves; h++) begin
         wait_strobe(h % 2 == 0 ? 1'b0 : 1'b1, got);
         chk({tag, " half period"}, got, nn);
      end
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk("R10 stopped clock low", sclk, 0);
   endtask

   initial begin
      int n, k, rxn, rxk, got;
      bit hold;
      string tg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 tx_psc", tx_psc, 31);
      chk("R1 tx_pow", tx_pow, 5);
      chk("R1 rx_psc", rx_psc, 31);
      chk("R1 rx_pow", rx_pow, 5);
      chk("R1 sclk", sclk, 0);
      chk("R1 strobes", {sclk_rise, sclk_fall}, 0);

      // Sweep every request 0..1100 with a mix of receive modes
      rxn = 32; rxk = 5;
      for (int r = 0; r <= 1100; r++) begin
         model(r, n, k);
         hold = (r % 7 == 3);
         tg = (r == 0) ? "R3" : ((r > 1024) ? "R4" : "R2");
         @(negedge clk);
         req_ratio = 11'(r);
         rx_follows_tx = hold;
         cfg_load = 1'b1;
         @(negedge clk);
         cfg_load = 1'b0;
         req_ratio = 11'(r) ^ 11'h155;
         chk({tg, " tx prescaler"}, tx_psc, n - 1);
         chk({tg, " tx binary code"}, tx_pow, k);
         if (!hold) begin
            rxn = n;
            rxk = k;
         end
         chk(hold ? "R6 rx untouched psc" : "R5 rx copy psc", rx_psc, rxn - 1);
         chk(hold ? "R6 rx untouched pow" : "R5 rx copy pow", rx_pow, rxk);
         @(negedge clk);
         chk("R7 tx held", {tx_pow, tx_psc}, {k[2:0], 5'(n - 1)});
         chk("R7 rx held", {rx_pow, rx_psc}, {rxk[2:0], 5'(rxn - 1)});
      end
      rx_follows_tx = 1'b0;

      // Edge timing for several ratios
      run_ratio(1, 6, "R11");
      run_ratio(2, 4, "R8");
      run_ratio(3, 4, "R8");
      run_ratio(7, 4, "R8");
      run_ratio(33, 3, "R8");
      run_ratio(64, 3, "R8");
      run_ratio(100, 3, "R8");
      run_ratio(1000, 2, "R8");
      run_ratio(0, 1, "R3");

      // R10: reconfiguration mid-phase is deferred to the next falling edge
      load_idle(4);
      @(negedge clk);
      run = 1'b1;
      wait_strobe(1'b1, got);
      chk("R10 first rise ratio 4", got, 4);
      req_ratio = 11'd2;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      wait_strobe(1'b0, got);
      chk("R10 high phase kept", got + 1, 4);
      wait_strobe(1'b1, got);
      chk("R10 new ratio after fall", got, 2);
      wait_strobe(1'b0, got);
      chk("R10 high at new ratio", got, 2);
      req_ratio = 11'd6;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      wait_strobe(1'b1, got);
      chk("R10 low phase kept", got + 1, 2);
      wait_strobe(1'b0, got);
      chk("R10 high phase still old", got, 2);
      wait_strobe(1'b1, got);
      chk("R10 later ratio adopted", got, 6);
      @(negedge clk);
      run = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R8: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule